// File: doc/BRIEF.md
# Unaligned Word Merge Load Unit

This block performs the two partial-word loads that let a processor build a 32-bit word from an unaligned byte address. It uses two aligned memory reads. A request carries four things: an operation kind, a byte address, the present value of the destination register, and the aligned memory word that holds the addressed byte. The unit returns the new register value. It overwrites some byte lanes with bytes from the memory word and keeps every other lane of the old value.

Memory is byte addressed and little-endian. Byte lane 0 is the least significant byte and sits at the lowest address. Only the two low address bits pick the lanes, so an access never reaches past its aligned word.

To read the word at an unaligned address A, software issues two operations:

1. A high-side merge at address A+3, using the aligned word that holds A+3.
2. A low-side merge at address A, using the aligned word that holds A. The result of the first operation is the old register value for this step.

The result is registered and is presented with a one-cycle strobe.

Top module: `ulm_load_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `valid_o` is 0 and `result_o` is 0.
- R2: `valid_o` is 1 in exactly the cycles that follow a cycle with `req_i` = 1, and is 0 otherwise.
- R3: With `op_i` = 0 (high-side merge) and offset k = `addr_i[1:0]`:
  - Register byte lane 3-i takes memory byte lane k-i, for i = 0..k.
  - The lower 3-k lanes keep their old value.
- R4: With `op_i` = 1 (low-side merge) and offset k:
  - Register byte lane i takes memory byte lane k+i, for i = 0..3-k.
  - The upper k lanes keep their old value.
- R5: Two cases return the memory word unchanged: a high-side merge with offset 3, and a low-side merge with offset 0.
- R6: Address bits above bit 1 have no effect on the result.
- R7: Two chained operations yield the little-endian word stored at bytes A..A+3:
  - first, a high-side merge at A+3;
  - then, a low-side merge at A whose old value is the first result.
- R8: In a cycle without a request, `result_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe |
| op_i | input | 1 | 0 = high-side merge, 1 = low-side merge |
| addr_i | input | ADDR_W (32) | Byte address |
| old_i | input | NB*BW (32) | Current destination register value |
| mem_i | input | NB*BW (32) | Aligned memory word holding the addressed byte |
| valid_o | output | 1 | Result strobe, one cycle after the request |
| result_o | output | NB*BW (32) | Merged register value |

## Verification
A new request can be captured in the same cycle that the previous result is presented. The bench therefore issues requests back to back with no idle cycle. It checks every presented result against a byte-by-byte model computed in the bench, while the next request is already loading.

Chained pairs test this overlap directly. The second operation's old value is taken from the first operation's output as soon as it appears. Back-to-back pairs that differ only in the upper address bits must show equal results in successive cycles. An idle cycle placed after such a run must drop the strobe and hold the value.

// File: rtl/ulm_pkg.sv
package ulm_pkg;

  typedef enum logic {
    LD_HIGH = 1'b0,
    LD_LOW  = 1'b1
  } ld_kind_e;

  // Does destination lane `lane` take a memory byte for this kind/offset?
  function automatic logic lane_taken(ld_kind_e kind, int lane, int k, int nb);
    if (kind == LD_HIGH) return (lane >= nb - 1 - k);
    else                 return (lane <= nb - 1 - k);
  endfunction

  // Which memory lane feeds destination lane `lane` (valid only when taken).
  function automatic int lane_source(ld_kind_e kind, int lane, int k, int nb);
    if (kind == LD_HIGH) return lane - (nb - 1 - k);
    else                 return lane + k;
  endfunction

  // Number of lanes replaced by a given kind/offset.
  function automatic int lanes_replaced(ld_kind_e kind, int k, int nb);
    if (kind == LD_HIGH) return k + 1;
    else                 return nb - k;
  endfunction

endpackage

// File: rtl/ulm_lane_ctrl.sv
module ulm_lane_ctrl
  import ulm_pkg::*;
#(
  parameter int NB = 4,
  localparam int OW = $clog2(NB)
) (
  input  ld_kind_e                kind,
  input  logic [OW-1:0]           offset,
  output logic [NB-1:0]           repl_mask,
  output logic [NB-1:0][OW-1:0]   src_sel
);

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign repl_mask[g] = lane_taken(kind, g, int'(offset), NB);
    assign src_sel[g]   = repl_mask[g] ? OW'(lane_source(kind, g, int'(offset), NB))
                                       : '0;
  end

endmodule

// File: rtl/ulm_merge.sv
module ulm_merge #(
  parameter int NB = 4,
  parameter int BW = 8,
  localparam int OW = $clog2(NB),
  localparam int DW = NB * BW
) (
  input  logic [DW-1:0]           old_word,
  input  logic [DW-1:0]           mem_word,
  input  logic [NB-1:0]           repl_mask,
  input  logic [NB-1:0][OW-1:0]   src_sel,
  output logic [DW-1:0]           merged
);

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [BW-1:0] picked;
    assign picked = mem_word[int'(src_sel[g]) * BW +: BW];
    assign merged[g*BW +: BW] = repl_mask[g] ? picked : old_word[g*BW +: BW];
  end

endmodule

// File: rtl/ulm_load_unit.sv
module ulm_load_unit
  import ulm_pkg::*;
#(
  parameter int NB     = 4,
  parameter int BW     = 8,
  parameter int ADDR_W = 32,
  localparam int OW = $clog2(NB),
  localparam int DW = NB * BW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     old_i,
  input  logic [DW-1:0]     mem_i,
  output logic              valid_o,
  output logic [DW-1:0]     result_o
);

  // Named internal events for the assertions
  ld_kind_e                   kind;
  logic [OW-1:0]              offset;
  logic [ADDR_W-OW-1:0]       word_idx;
  logic [NB-1:0]              repl_mask;
  logic [NB-1:0][OW-1:0]      src_sel;
  logic [DW-1:0]              merged;
  logic                       full_word;

  assign kind      = ld_kind_e'(op_i);
  assign offset    = addr_i[OW-1:0];
  assign word_idx  = addr_i[ADDR_W-1:OW];
  assign full_word = (kind == LD_HIGH && offset == OW'(NB-1)) ||
                     (kind == LD_LOW  && offset == '0);

  ulm_lane_ctrl #(.NB(NB)) u_ctrl (
    .kind      (kind),
    .offset    (offset),
    .repl_mask (repl_mask),
    .src_sel   (src_sel)
  );

  ulm_merge #(.NB(NB), .BW(BW)) u_merge (
    .old_word  (old_i),
    .mem_word  (mem_i),
    .repl_mask (repl_mask),
    .src_sel   (src_sel),
    .merged    (merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= req_i;
      if (req_i) result_o <= merged;
    end
  end

  // Strobe follows request by one cycle
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> valid_o);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !valid_o);

  // High-side merge keeps the bottom lane unless the whole word is taken
  assert_high_keeps_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && kind == LD_HIGH && offset != OW'(NB-1))
      |=> result_o[BW-1:0] == $past(old_i[BW-1:0]));

  // Low-side merge keeps the top lane unless the whole word is taken
  assert_low_keeps_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && kind == LD_LOW && offset != '0)
      |=> result_o[DW-1 -: BW] == $past(old_i[DW-1 -: BW]));

  // Lane count taken matches the offset rule
  assert_lane_count_R3_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |-> $countones(repl_mask) == lanes_replaced(kind, int'(offset), NB));

  // Full-word cases return the memory word
  assert_full_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && full_word) |=> result_o == $past(mem_i));

  // Upper address bits do not change the outcome
  assert_addr_upper_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && $past(req_i) && op_i == $past(op_i) && offset == $past(offset) &&
     old_i == $past(old_i) && mem_i == $past(mem_i) && word_idx != $past(word_idx))
      |=> result_o == $past(result_o));

  // No request, no change
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> $stable(result_o));

endmodule

// File: tb/test_ulm_load_unit.sv
module test_ulm_load_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i;
  logic        op_i;
  logic [31:0] addr_i;
  logic [31:0] old_i;
  logic [31:0] mem_i;
  logic        valid_o;
  logic [31:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  ulm_load_unit i_ulm_load_unit (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .op_i(op_i), .addr_i(addr_i),
    .old_i(old_i), .mem_i(mem_i), .valid_o(valid_o), .result_o(result_o)
  );

  // Byte-list model: walk bytes from the filled end
  function automatic logic [31:0] model(bit low_side, int k, logic [31:0] old_v,
                                        logic [31:0] mem_v);
    logic [31:0] r = old_v;
    if (!low_side) begin
      for (int i = 0; i <= k; i++) r[(3-i)*8 +: 8] = mem_v[(k-i)*8 +: 8];
    end else begin
      for (int i = 0; i < 4 - k; i++) r[i*8 +: 8] = mem_v[(k+i)*8 +: 8];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, then check at the next falling edge
  task automatic issue(bit op, logic [31:0] addr, logic [31:0] old_v,
                       logic [31:0] mem_v, string tag);
    logic [31:0] exp;
    req_i  = 1'b1;
    op_i   = op;
    addr_i = addr;
    old_i  = old_v;
    mem_i  = mem_v;
    exp    = model(op, int'(addr[1:0]), old_v, mem_v);
    @(negedge clk);
    check({tag, " valid R2"}, {31'd0, valid_o}, 32'd1);
    check(tag, result_o, exp);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] last;
    logic [7:0]  mem8 [8];
    logic [31:0] w0;
    logic [31:0] w1;
    logic [31:0] first;
    logic [31:0] want;

    rst_n = 1'b0; req_i = 1'b0; op_i = 1'b0;
    addr_i = '0; old_i = '0; mem_i = '0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {31'd0, valid_o}, 32'd0);
    check("R1 result in reset", result_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", {31'd0, valid_o}, 32'd0);
    check("R1 result after reset", result_o, 32'd0);

    // Sweep: kind x offset x data patterns, back to back (R3, R4, R5)
    for (int op = 0; op < 2; op++) begin
      for (int k = 0; k < 4; k++) begin
        for (int p = 0; p < 6; p++) begin
          logic [31:0] o;
          logic [31:0] m;
          o = 32'hA0B0C0D0 ^ (32'(p) * 32'h01030507);
          m = 32'h13579BDF * 32'(p + 1) + 32'h2468ACE0;
          issue(op[0], {28'(p * 5 + 1), 2'(k), 2'b00} >> 2 << 2 | 32'(k), o, m,
                op == 0 ? "R3 high merge" : "R4 low merge");
          if ((op == 0 && k == 3) || (op == 1 && k == 0))
            check("R5 full word", result_o, m);
        end
      end
    end

    // Idle: strobe drops, value holds (R2, R8)
    last  = result_o;
    req_i = 1'b0;
    mem_i = 32'hDEADBEEF;
    old_i = 32'h01234567;
    @(negedge clk);
    check("R2 idle valid", {31'd0, valid_o}, 32'd0);
    check("R8 hold", result_o, last);
    @(negedge clk);
    check("R8 hold second cycle", result_o, last);

    // Upper address bits ignored, back to back (R6)
    for (int k = 0; k < 4; k++) begin
      issue(1'b0, 32'h00000000 | 32'(k), 32'h11223344, 32'h8899AABB, "R6 base");
      last = result_o;
      issue(1'b0, 32'hFFFFFFF0 | 32'(k), 32'h11223344, 32'h8899AABB, "R6 upper bits");
      check("R6 equal result", result_o, last);
    end

    // Chained pair assembles the unaligned word (R7)
    for (int i = 0; i < 8; i++) mem8[i] = 8'(8'h31 + i * 8'h17);
    w0 = {mem8[3], mem8[2], mem8[1], mem8[0]};
    w1 = {mem8[7], mem8[6], mem8[5], mem8[4]};
    for (int a = 0; a < 4; a++) begin
      logic [31:0] hi_word;
      hi_word = (a + 3 >= 4) ? w1 : w0;
      issue(1'b0, 32'h00000100 + 32'(a + 3), 32'hCAFEF00D, hi_word, "R7 first");
      first = result_o;
      issue(1'b1, 32'h00000100 + 32'(a), first, w0, "R7 second");
      want = {mem8[a+3], mem8[a+2], mem8[a+1], mem8[a]};
      check("R7 assembled word", result_o, want);
    end

    req_i = 1'b0;
    @(negedge clk);
    check("R2 final idle", {31'd0, valid_o}, 32'd0);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule